// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two data words lane by lane. Each word is split into narrow packed lanes of either 8 or 16 bits, and every lane pair is added on its own. No carry passes from one lane into the next. The operation mode sets how each lane sum is finished:

- **Arithmetic:** modular (wrap-around) or clamped (saturating).
- **Lane type:** unsigned or two's-complement signed.
- **Averaging:** the sum can be used as is, halved after wrapping or clamping, or halved exactly with the carry bit kept.

When a lane is clamped, the lane raises a sticky saturation flag. The flag stays high until a clear input is asserted. Software can therefore check once, after a long run of samples, whether any lane overflowed.

The block has one register stage. An operation presented with `in_valid` at a rising edge appears on `res` one cycle later. A two-state controller tracks whether the result register holds fresh data:

- **ST_EMPTY:** reset state; no fresh result.
- **ST_FULL:** a result was captured on the last edge.

The transitions are:

- **ACCEPT:** EMPTY to FULL when `in_valid` is high.
- **REFILL:** FULL to FULL when `in_valid` is high.
- **DRAIN:** FULL to EMPTY when `in_valid` is low.
- **STAY:** EMPTY to EMPTY when `in_valid` is low.

`res_valid` is high exactly in ST_FULL.

Top module: `simd_sat_adder`

## Requirements
- R1: No carry crosses a lane boundary. In wrap mode (`op_sat`=0, `op_avg`=00), each L-bit lane of `res` equals (lane of `opa` + lane of `opb`) mod 2^L. Lane i occupies bits [i*L+L-1 : i*L].
- R2: `lane16`=1 selects W/16 lanes of 16 bits. `lane16`=0 selects W/8 lanes of 8 bits. The same operands give different results in the two widths.
- R3: With unsigned saturation (`op_sat`=1, `op_signed`=0), a lane whose true sum exceeds 2^L-1 gives 2^L-1 (0xFF or 0xFFFF).
- R4: With signed saturation (`op_sat`=1, `op_signed`=1):
  - overflow gives 0x7F for 8-bit lanes and 0x7FFF for 16-bit lanes;
  - underflow gives 0x80 for 8-bit lanes and 0x8000 for 16-bit lanes.
- R5: `op_avg`=01 halves the finished lane value (wrapped or clamped) by a one-bit right shift. The shift is arithmetic for signed lanes and logical for unsigned lanes. Example, unsigned 8-bit lanes with 0x7F+0x81: wrap mode gives 0x00 and saturating mode gives 0x7F.
- R6: `op_avg`=10 or 11 gives the exact average, floor((a+b)/2), computed with the carry bit kept. The 0x7F+0x81 example gives 0x80. This mode never raises a saturation flag.
- R7: `sat_flags` bit i is set when lane i clamps in an accepted operation, and it stays set afterwards. With 16-bit lanes only bits 0 to W/16-1 can be set.
- R8: `flag_clr` clears all flags at the next edge. A clamp in an operation accepted on that same edge still sets its own flag.
- R9: The result appears one cycle after acceptance, with `res_valid` high for that cycle. When `in_valid` is low, `res_valid` falls and `res` holds its last value.
- R10: After reset, `res`, `res_valid` and `sat_flags` are all zero.
- R11: Wrap mode (`op_sat`=0) never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| lane16 | input | 1 | 1: 16-bit lanes, 0: 8-bit lanes |
| op_sat | input | 1 | 1: saturating, 0: wrap-around |
| op_signed | input | 1 | 1: signed lanes, 0: unsigned lanes |
| op_avg | input | 2 | 00 plain, 01 halve finished value, 1x exact average |
| flag_clr | input | 1 | Clear all sticky saturation flags |
| opa | input | W | First packed operand |
| opb | input | W | Second packed operand |
| res | output | W | Packed lane results |
| res_valid | output | 1 | Result register holds a fresh result |
| sat_flags | output | W/8 | Sticky per-lane saturation flags |

## Verification
The hardest cases to reach are the exact lane boundaries:

- a sum one above a lane's maximum;
- a signed sum exactly at the minimum;
- a carry that would ripple into the neighbouring lane only when the lane width is the smaller one.

Uniform random operands rarely land on these values. The stimulus therefore mixes directed operands with random words built from lane values such as 0x7F, 0x80, 0xFF, 0x00 and 0x01. A clear asserted on the same edge as a clamping operation is also driven on purpose.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ctl_state_t;

    typedef enum logic [1:0] {
        AVG_NONE  = 2'b00,
        AVG_HALF  = 2'b01,
        AVG_EXACT = 2'b10,
        AVG_EXALT = 2'b11
    } avg_mode_t;

    localparam int NARROW_W = 8;
    localparam int WIDE_W   = 16;

endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          sgn,
    input  logic          sat,
    input  logic [1:0]    avg,
    output logic [LW-1:0] y,
    output logic          clamp
);
    import simd_pkg::*;

    localparam int EW = LW + 2;

    logic signed [EW-1:0] ext_a;
    logic signed [EW-1:0] ext_b;
    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] max_v;
    logic signed [EW-1:0] min_v;
    logic                 over;
    logic                 under;
    logic [LW-1:0]        base;
    logic [LW-1:0]        halved;
    avg_mode_t            mode;

    always_comb begin
        mode  = avg_mode_t'(avg);
        ext_a = sgn ? $signed({{2{a[LW-1]}}, a}) : $signed({2'b00, a});
        ext_b = sgn ? $signed({{2{b[LW-1]}}, b}) : $signed({2'b00, b});
        max_v = sgn ? $signed({3'b000, {(LW-1){1'b1}}})
                    : $signed({2'b00, {LW{1'b1}}});
        min_v = sgn ? $signed({3'b111, {(LW-1){1'b0}}})
                    : $signed({EW{1'b0}});
        sum   = ext_a + ext_b;
        over  = sum > max_v;
        under = sum < min_v;

        if (sat && over) begin
            base = max_v[LW-1:0];
        end else if (sat && under) begin
            base = min_v[LW-1:0];
        end else begin
            base = sum[LW-1:0];
        end

        halved = {sgn & base[LW-1], base[LW-1:1]};

        unique case (mode)
            AVG_NONE:  y = base;
            AVG_HALF:  y = halved;
            default:   y = sum[LW:1];
        endcase

        clamp = sat & (over | under) & ~avg[1];
    end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
    parameter int W = 32
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic           lane16,
    input  logic           sgn,
    input  logic           sat,
    input  logic [1:0]     avg,
    output logic [W-1:0]   y,
    output logic [W/8-1:0] clamp
);
    import simd_pkg::*;

    localparam int NB = W / NARROW_W;
    localparam int NH = W / WIDE_W;

    logic [W-1:0]  y_nar;
    logic [W-1:0]  y_wid;
    logic [NB-1:0] c_nar;
    logic [NH-1:0] c_wid;

    for (genvar i = 0; i < NB; i++) begin : g_nar
        simd_lane #(.LW(NARROW_W)) u_lane (
            .a     (opa[i*NARROW_W +: NARROW_W]),
            .b     (opb[i*NARROW_W +: NARROW_W]),
            .sgn   (sgn),
            .sat   (sat),
            .avg   (avg),
            .y     (y_nar[i*NARROW_W +: NARROW_W]),
            .clamp (c_nar[i])
        );
    end

    for (genvar j = 0; j < NH; j++) begin : g_wid
        simd_lane #(.LW(WIDE_W)) u_lane (
            .a     (opa[j*WIDE_W +: WIDE_W]),
            .b     (opb[j*WIDE_W +: WIDE_W]),
            .sgn   (sgn),
            .sat   (sat),
            .avg   (avg),
            .y     (y_wid[j*WIDE_W +: WIDE_W]),
            .clamp (c_wid[j])
        );
    end

    always_comb begin
        if (lane16) begin
            y     = y_wid;
            clamp = {{(NB-NH){1'b0}}, c_wid};
        end else begin
            y     = y_nar;
            clamp = c_nar;
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           lane16,
    input  logic           op_sat,
    input  logic           op_signed,
    input  logic [1:0]     op_avg,
    input  logic           flag_clr,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   res,
    output logic           res_valid,
    output logic [W/8-1:0] sat_flags
);
    import simd_pkg::*;

    localparam int NF = W / NARROW_W;
    localparam int NH = W / WIDE_W;

    ctl_state_t    state_q;
    ctl_state_t    state_d;
    logic [W-1:0]  sum_d;
    logic [NF-1:0] clamp_d;
    logic [W-1:0]  res_q;
    logic [NF-1:0] flag_q;

    simd_lane_array #(.W(W)) u_array (
        .opa    (opa),
        .opb    (opb),
        .lane16 (lane16),
        .sgn    (op_signed),
        .sat    (op_sat),
        .avg    (op_avg),
        .y      (sum_d),
        .clamp  (clamp_d)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // data and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            flag_q <= '0;
        end else begin
            if (in_valid) begin
                res_q <= sum_d;
            end
            flag_q <= (flag_clr ? '0 : flag_q) | (in_valid ? clamp_d : '0);
        end
    end

    // outputs
    always_comb begin
        res       = res_q;
        res_valid = (state_q == ST_FULL);
        sat_flags = flag_q;
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R9
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid); // R9
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((sat_flags & $past(sat_flags)) == $past(sat_flags))); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> (sat_flags == '0)); // R8
    AST_WRAP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sat && !flag_clr) |=> $stable(sat_flags)); // R11
    AST_EXACT_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_avg[1] && !flag_clr) |=> $stable(sat_flags)); // R6
    AST_WIDE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane16 && !flag_clr) |=>
            (sat_flags[NF-1:NH] == $past(sat_flags[NF-1:NH]))); // R7

endmodule

// File: tb/tb_simd_sat_adder.sv
`timescale 1ns/1ps
module tb_simd_sat_adder;
    localparam int W  = 32;
    localparam int NF = W / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          lane16 = 1'b0;
    logic          op_sat = 1'b0;
    logic          op_signed = 1'b0;
    logic [1:0]    op_avg = 2'b00;
    logic          flag_clr = 1'b0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [W-1:0]  res;
    logic          res_valid;
    logic [NF-1:0] sat_flags;

    int checks = 0;
    int fails  = 0;
    logic [NF-1:0] mflags = '0;
    logic [W-1:0]  last_res;

    always #4 clk = ~clk;

    simd_sat_adder #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane16(lane16),
        .op_sat(op_sat), .op_signed(op_signed), .op_avg(op_avg),
        .flag_clr(flag_clr), .opa(opa), .opb(opb),
        .res(res), .res_valid(res_valid), .sat_flags(sat_flags)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit l16, input bit sat, input bit sgn,
                                  input bit [1:0] avg,
                                  output logic [W-1:0] r, output logic [NF-1:0] f);
        int L = l16 ? 16 : 8;
        int n = W / L;
        int mask = (1 << L) - 1;
        r = '0;
        f = '0;
        for (int i = 0; i < n; i++) begin
            int ua, ub, va, vb, s, mx, mn, basep, y;
            bit cl;
            logic [W-1:0] t;
            ua = int'(a >> (i*L)) & mask;
            ub = int'(b >> (i*L)) & mask;
            va = (sgn && ua >= (1 << (L-1))) ? ua - (1 << L) : ua;
            vb = (sgn && ub >= (1 << (L-1))) ? ub - (1 << L) : ub;
            s  = va + vb;
            mx = sgn ? (1 << (L-1)) - 1 : mask;
            mn = sgn ? -(1 << (L-1)) : 0;
            cl = 1'b0;
            if (sat && s > mx) begin basep = mx & mask; cl = 1'b1; end
            else if (sat && s < mn) begin basep = mn & mask; cl = 1'b1; end
            else basep = s & mask;
            if (avg[1]) begin
                y = (s >>> 1) & mask;
                cl = 1'b0;
            end else if (avg[0]) begin
                y = (basep >> 1) | ((sgn && basep[L-1]) ? (1 << (L-1)) : 0);
            end else begin
                y = basep;
            end
            t = W'(y & mask);
            r = r | (t << (i*L));
            f[i] = cl;
        end
    endfunction

    // one operation: drive at negedge, result sampled at the following negedge
    task automatic op(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit l16, input bit sat, input bit sgn, input bit [1:0] avg,
                      input bit clr);
        logic [W-1:0]  er;
        logic [NF-1:0] ef;
        model(a, b, l16, sat, sgn, avg, er, ef);
        @(negedge clk);
        opa = a; opb = b; lane16 = l16; op_sat = sat; op_signed = sgn;
        op_avg = avg; flag_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        mflags = (clr ? '0 : mflags) | ef;
        check({tag, " result"}, 64'(res), 64'(er));
        check({tag, " flags"}, 64'(sat_flags), 64'(mflags));
        check({tag, " valid"}, 64'(res_valid), 64'd1);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        mflags = '0;
        check("R8 clear", 64'(sat_flags), 64'd0);
    endtask

    function automatic logic [W-1:0] edge_word();
        logic [W-1:0] w;
        for (int i = 0; i < NF; i++) begin
            case ($urandom % 6)
                0: w[i*8 +: 8] = 8'h7F;
                1: w[i*8 +: 8] = 8'h80;
                2: w[i*8 +: 8] = 8'hFF;
                3: w[i*8 +: 8] = 8'h00;
                4: w[i*8 +: 8] = 8'h01;
                default: w[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return w;
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 res", 64'(res), 64'd0);
        check("R10 valid", 64'(res_valid), 64'd0);
        check("R10 flags", 64'(sat_flags), 64'd0);
        rst_n = 1'b1;

        // R1 carry cut at lane boundaries
        op("R1 wide", 32'h0000FFFF, 32'h00000001, 1, 0, 0, 2'b00, 0);
        check("R1 wide const", 64'(res), 64'h00000000);
        op("R1 narrow", 32'h00FF00FF, 32'h00010001, 0, 0, 0, 2'b00, 0);
        check("R1 narrow const", 64'(res), 64'h00000000);

        // R2 width select: same operands, two widths
        op("R2 narrow", 32'h000000FF, 32'h00000001, 0, 0, 0, 2'b00, 0);
        check("R2 narrow const", 64'(res), 64'h00000000);
        op("R2 wide", 32'h000000FF, 32'h00000001, 1, 0, 0, 2'b00, 0);
        check("R2 wide const", 64'(res), 64'h00000100);

        // R11 wrap overflow leaves flags untouched
        check("R11 flags", 64'(sat_flags), 64'd0);

        // R3 unsigned saturation
        op("R3 sat", 32'hF0F00101, 32'h20200101, 0, 1, 0, 2'b00, 0);
        check("R3 const", 64'(res), 64'hFFFF0202);
        check("R7 lanes", 64'(sat_flags), 64'b1100);
        clear_flags();

        // R4 signed saturation, 16-bit and 8-bit
        op("R4 wide", 32'h70009000, 32'h20009000, 1, 1, 1, 2'b00, 0);
        check("R4 wide const", 64'(res), 64'h7FFF8000);
        check("R7 wide bits", 64'(sat_flags), 64'b0011);
        op("R4 narrow", 32'h70900000, 32'h20900000, 0, 1, 1, 2'b00, 0);
        check("R4 narrow const", 64'(res), 64'h7F800000);

        // R8 clear with same-edge clamp
        op("R8 same edge", 32'h000000FF, 32'h00000001, 0, 1, 0, 2'b00, 1);
        check("R8 const", 64'(sat_flags), 64'b0001);
        clear_flags();

        // R5 halve after wrap and after saturate
        op("R5 wrap", 32'h0000007F, 32'h00000081, 0, 0, 0, 2'b01, 0);
        check("R5 wrap const", 64'(res), 64'h00000000);
        op("R5 sat", 32'h0000007F, 32'h00000081, 0, 1, 0, 2'b01, 0);
        check("R5 sat const", 64'(res), 64'h0000007F);
        clear_flags();

        // R6 exact average
        op("R6 exact", 32'h0000007F, 32'h00000081, 0, 1, 0, 2'b10, 0);
        check("R6 const", 64'(res), 64'h00000080);
        check("R6 noflag", 64'(sat_flags), 64'd0);

        // R9 hold when idle
        last_res = res;
        @(negedge clk);
        check("R9 valid drop", 64'(res_valid), 64'd0);
        opa = '1;
        @(negedge clk);
        check("R9 hold", 64'(res), 64'(last_res));

        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] a, b;
            bit [1:0] av;
            a  = (k % 2) ? edge_word() : W'($urandom);
            b  = (k % 3) ? edge_word() : W'($urandom);
            av = 2'($urandom);
            op("R1 R3 R4 R5 R6 R7 random", a, b, 1'($urandom), 1'($urandom),
               1'($urandom), av, ($urandom % 8) == 0);
        end

        report();
    end
endmodule